// File: doc/BRIEF.md
# Burst-of-Four Dual-Port DDR Line Memory

This block is a synthesizable behavioural model of a synchronous memory with one port that only reads and one that only writes. Both ports can be used at the same time. Every access moves one line of four 18-bit words. Data moves twice per clock, so a line takes two clock cycles on either port. The single clock domain models the two clock edges as two half-cycle slots per cycle. The first half is called "rise" and the second half "fall". Each data port carries one word per slot.

A line address is a word address with its two lowest bits removed. The block generates those two bits itself: 0 for the first beat, then 1, 2 and 3. The address bus is shared by both ports and carries two values per cycle. The rise half gives the read line and the fall half gives the write line, so a read and a write can start in the same cycle.

Writes carry two per-byte-lane enables with every beat, so each beat can mask its two 9-bit lanes on its own. The array is updated once the whole line has been captured. Reads are pipelined, with the first word appearing 1.5 cycles after the command. A read that overlaps a write still in flight returns the newest data. A command that arrives while its port is still busy with a line is dropped and flagged.

Top module: `burst4_ddr_sram`

## Requirements
- R1: A read accepted at clock edge E returns line words 0..3 as follows. At edge E+1, rd_data_fall carries word 0. At edge E+2, rd_data_rise carries word 1 and rd_data_fall carries word 2. At edge E+3, rd_data_rise carries word 3. The word address of beat b is {line, b}. Each half's valid flag is 1 exactly when that half carries a beat. A data half that carries no beat reads 0.
- R2: A write accepted at edge E takes beat 0 from wr_data_rise and beat 1 from wr_data_fall at edge E. It takes beat 2 from wr_data_rise and beat 3 from wr_data_fall at edge E+1. Each beat uses the enables presented with it. The line is written to the array at edge E+1.
- R3: Bit i of a beat's byte enable (wr_be_rise or wr_be_fall) writes lane i, which is data bits [9i+8:9i] of that beat. A lane whose enable is 0 keeps its previous content. An enable of 2'b00 on all four beats leaves the line unchanged.
- R4: addr_rise gives the read line and addr_fall gives the write line. A read and a write to different lines in the same cycle do not disturb each other.
- R5: A read accepted at the same edge as a write, or at any later edge, returns the data of that write. This includes a read and a write to the same line in the same cycle, where only the enabled lanes take the new value.
- R6: After a read is accepted at edge E, a read request at edge E+1 is ignored. rd_reject is then 1 for the cycle after that edge, and no extra data appears.
- R7: After a write is accepted at edge E, a write request at edge E+1 is ignored. wr_reject is then 1 for the cycle after that edge, and the array is not changed by the ignored request.
- R8: A synchronous low rst_n clears both valid flags, both read data halves and both reject flags. It abandons any read burst in progress, so no remaining beats appear after reset.
- R9: Reads accepted at edges E and E+2 stream without a gap. At edge E+3, rd_data_rise carries word 3 of the first line and rd_data_fall carries word 0 of the second line, with both valid flags 1.
- R10: A read accepted one edge before a write to the same line returns the line's old content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every edge is sampled rising |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel | input | 1 | Read request |
| wr_sel | input | 1 | Write request |
| addr_rise | input | LINE_AW | Line address, first half (read line) |
| addr_fall | input | LINE_AW | Line address, second half (write line) |
| wr_data_rise | input | 18 | Write beat of the first half |
| wr_data_fall | input | 18 | Write beat of the second half |
| wr_be_rise | input | 2 | Lane enables for the first-half write beat |
| wr_be_fall | input | 2 | Lane enables for the second-half write beat |
| rd_data_rise | output | 18 | Read beat of the first half |
| rd_data_fall | output | 18 | Read beat of the second half |
| rd_valid_rise | output | 1 | First-half read beat is valid |
| rd_valid_fall | output | 1 | Second-half read beat is valid |
| rd_reject | output | 1 | A read request was ignored in the previous cycle |
| wr_reject | output | 1 | A write request was ignored in the previous cycle |

## Verification
A write commit and a read snapshot of the same line can fall on the same edge. When they do, the read must merge the lanes that the committing write enables over the array contents. The bench provokes this by issuing a read and a write of one line in the same cycle, with different lane masks on each beat. Every returned beat is compared with a reference array in which the write is applied before the read. The one-cycle-earlier case is provoked as well, where the read must see the old data.

// File: rtl/burst4_pkg.sv
`timescale 1ns/1ps
package burst4_pkg;
  localparam int LANE_W        = 9;
  localparam int LANES         = 2;
  localparam int WORD_W        = LANE_W * LANES;
  localparam int BEATS         = 4;
  localparam int BEATS_PER_CYC = 2;
  localparam int BURST_CYC     = BEATS / BEATS_PER_CYC;
  localparam int BEAT_W        = $clog2(BEATS);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [LANES-1:0]   lmask_t;
  typedef word_t  [BEATS-1:0] line_t;
  typedef lmask_t [BEATS-1:0] lmasks_t;

  typedef enum logic [1:0] {
    RP_IDLE,
    RP_PAIR,
    RP_TAIL
  } rphase_t;

  // Replace the enabled lanes of old_w with those of new_w.
  function automatic word_t lane_merge(word_t old_w, word_t new_w, lmask_t en);
    word_t r;
    r = old_w;
    for (int l = 0; l < LANES; l++) begin
      if (en[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  // Beat-wise lane merge of a whole line.
  function automatic line_t line_merge(line_t old_l, line_t new_l, lmasks_t en);
    line_t r;
    for (int b = 0; b < BEATS; b++) begin
      r[b] = lane_merge(old_l[b], new_l[b], en[b]);
    end
    return r;
  endfunction
endpackage

// File: rtl/burst4_cmd_gate.sv
`timescale 1ns/1ps
// Accepts one command per HOLD_CYC cycles; drops and flags the rest.
module burst4_cmd_gate #(
  parameter  int HOLD_CYC = 2,
  localparam int CW       = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  output logic accept,
  output logic reject
);
  logic [CW-1:0] left_q;
  logic          busy;

  assign busy   = (left_q != '0);
  assign accept = sel & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      reject <= 1'b0;
    end else begin
      reject <= sel & busy;
      if (accept)    left_q <= CW'(HOLD_CYC - 1);
      else if (busy) left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/burst4_array.sv
`timescale 1ns/1ps
// Word storage with a four-word line write port (per-lane enables)
// and a four-word combinational line read port.
module burst4_array
  import burst4_pkg::*;
#(
  parameter  int DEPTH   = 256,
  localparam int WORD_AW = $clog2(DEPTH),
  localparam int LINE_AW = WORD_AW - BEAT_W
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LINE_AW-1:0] waddr,
  input  line_t              wdata,
  input  lmasks_t            wen,
  input  logic [LINE_AW-1:0] raddr,
  output line_t              rdata
);
  word_t mem [DEPTH];

  function automatic logic [WORD_AW-1:0] word_index(logic [LINE_AW-1:0] line, int beat);
    return {line, BEAT_W'(beat)};
  endfunction

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BEATS; b++) begin
        for (int l = 0; l < LANES; l++) begin
          if (wen[b][l])
            mem[word_index(waddr, b)][l*LANE_W +: LANE_W] <= wdata[b][l*LANE_W +: LANE_W];
        end
      end
    end
  end

  for (genvar b = 0; b < BEATS; b++) begin : g_rd
    assign rdata[b] = mem[word_index(raddr, b)];
  end
endmodule

// File: rtl/burst4_wr_path.sv
`timescale 1ns/1ps
// Holds the first two beats of a write and presents the full line
// for commit on the following edge, together with the live beats.
module burst4_wr_path
  import burst4_pkg::*;
#(
  parameter int LINE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [LINE_AW-1:0] addr_in,
  input  word_t              d_rise,
  input  word_t              d_fall,
  input  lmask_t             be_rise,
  input  lmask_t             be_fall,
  output logic               commit,
  output logic [LINE_AW-1:0] commit_addr,
  output line_t              commit_data,
  output lmasks_t            commit_en
);
  logic               pend_q;
  logic [LINE_AW-1:0] addr_q;
  word_t              d0_q, d1_q;
  lmask_t             m0_q, m1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      m0_q   <= '0;
      m1_q   <= '0;
    end else begin
      pend_q <= accept;
      if (accept) begin
        addr_q <= addr_in;
        d0_q   <= d_rise;
        d1_q   <= d_fall;
        m0_q   <= be_rise;
        m1_q   <= be_fall;
      end
    end
  end

  assign commit      = pend_q;
  assign commit_addr = addr_q;

  always_comb begin
    commit_data[0] = d0_q;
    commit_data[1] = d1_q;
    commit_data[2] = d_rise;
    commit_data[3] = d_fall;
    commit_en[0]   = m0_q;
    commit_en[1]   = m1_q;
    commit_en[2]   = be_rise;
    commit_en[3]   = be_fall;
  end
endmodule

// File: rtl/burst4_rd_path.sv
`timescale 1ns/1ps
// Read pipeline: snapshot of the line one edge after accept (with
// forwarding from a committing write), then beat shaping onto the halves.
module burst4_rd_path
  import burst4_pkg::*;
#(
  parameter int LINE_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [LINE_AW-1:0] addr_in,
  output logic [LINE_AW-1:0] snap_addr,
  input  line_t              arr_line,
  input  logic               wcommit,
  input  logic [LINE_AW-1:0] waddr,
  input  line_t              wdata,
  input  lmasks_t            wen,
  output logic               snap,
  output logic               fwd_hit,
  output word_t              q_rise,
  output word_t              q_fall,
  output logic               v_rise,
  output logic               v_fall
);
  logic               snap_q;
  logic [LINE_AW-1:0] addr_q;
  line_t              line_q;
  line_t              snap_line;
  rphase_t            phase_q;

  assign snap      = snap_q;
  assign snap_addr = addr_q;
  assign fwd_hit   = snap_q & wcommit & (waddr == addr_q);
  assign snap_line = fwd_hit ? line_merge(arr_line, wdata, wen) : arr_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= 1'b0;
      addr_q  <= '0;
      line_q  <= '0;
      phase_q <= RP_IDLE;
      q_rise  <= '0;
      q_fall  <= '0;
      v_rise  <= 1'b0;
      v_fall  <= 1'b0;
    end else begin
      snap_q <= accept;
      if (accept) addr_q <= addr_in;
      if (snap_q) line_q <= snap_line;

      v_rise <= (phase_q != RP_IDLE);
      case (phase_q)
        RP_PAIR: q_rise <= line_q[1];
        RP_TAIL: q_rise <= line_q[3];
        default: q_rise <= '0;
      endcase

      v_fall <= (phase_q == RP_PAIR) | snap_q;
      if (phase_q == RP_PAIR) q_fall <= line_q[2];
      else if (snap_q)        q_fall <= snap_line[0];
      else                    q_fall <= '0;

      if (snap_q)                  phase_q <= RP_PAIR;
      else if (phase_q == RP_PAIR) phase_q <= RP_TAIL;
      else                         phase_q <= RP_IDLE;
    end
  end
endmodule

// File: rtl/burst4_ddr_sram.sv
`timescale 1ns/1ps
module burst4_ddr_sram
  import burst4_pkg::*;
#(
  parameter  int DEPTH   = 256,
  localparam int WORD_AW = $clog2(DEPTH),
  localparam int LINE_AW = WORD_AW - BEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_sel,
  input  logic               wr_sel,
  input  logic [LINE_AW-1:0] addr_rise,
  input  logic [LINE_AW-1:0] addr_fall,
  input  logic [WORD_W-1:0]  wr_data_rise,
  input  logic [WORD_W-1:0]  wr_data_fall,
  input  logic [LANES-1:0]   wr_be_rise,
  input  logic [LANES-1:0]   wr_be_fall,
  output logic [WORD_W-1:0]  rd_data_rise,
  output logic [WORD_W-1:0]  rd_data_fall,
  output logic               rd_valid_rise,
  output logic               rd_valid_fall,
  output logic               rd_reject,
  output logic               wr_reject
);
  // Named internal events (observed by the bound checker).
  logic               rd_acc;
  logic               wr_acc;
  logic               wr_commit;
  logic               rd_snap;
  logic               fwd_hit;

  logic [LINE_AW-1:0] commit_addr;
  line_t              commit_data;
  lmasks_t            commit_en;
  logic [LINE_AW-1:0] snap_addr;
  line_t              arr_line;
  word_t              q_rise, q_fall;

  burst4_cmd_gate #(.HOLD_CYC(BURST_CYC)) u_rd_gate (
    .clk(clk), .rst_n(rst_n), .sel(rd_sel), .accept(rd_acc), .reject(rd_reject)
  );

  burst4_cmd_gate #(.HOLD_CYC(BURST_CYC)) u_wr_gate (
    .clk(clk), .rst_n(rst_n), .sel(wr_sel), .accept(wr_acc), .reject(wr_reject)
  );

  burst4_wr_path #(.LINE_AW(LINE_AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .accept(wr_acc), .addr_in(addr_fall),
    .d_rise(wr_data_rise), .d_fall(wr_data_fall),
    .be_rise(wr_be_rise), .be_fall(wr_be_fall),
    .commit(wr_commit), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_en(commit_en)
  );

  burst4_array #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_commit), .waddr(commit_addr), .wdata(commit_data),
    .wen(commit_en), .raddr(snap_addr), .rdata(arr_line)
  );

  burst4_rd_path #(.LINE_AW(LINE_AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .accept(rd_acc), .addr_in(addr_rise),
    .snap_addr(snap_addr), .arr_line(arr_line),
    .wcommit(wr_commit), .waddr(commit_addr), .wdata(commit_data), .wen(commit_en),
    .snap(rd_snap), .fwd_hit(fwd_hit),
    .q_rise(q_rise), .q_fall(q_fall), .v_rise(rd_valid_rise), .v_fall(rd_valid_fall)
  );

  assign rd_data_rise = q_rise;
  assign rd_data_fall = q_fall;
endmodule

// File: rtl/burst4_ddr_sram_chk.sv
`timescale 1ns/1ps
module burst4_ddr_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_sel,
  input logic wr_sel,
  input logic rd_acc,
  input logic wr_acc,
  input logic wr_commit,
  input logic rd_snap,
  input logic fwd_hit,
  input logic rd_valid_rise,
  input logic rd_valid_fall,
  input logic rd_reject,
  input logic wr_reject
);
  // R1: a lone word 0 on the fall half is followed by a full pair.
  assert_lead_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_fall && !rd_valid_rise) |=> (rd_valid_rise && rd_valid_fall));

  // R1: a lone word 3 on the rise half follows a full pair.
  assert_tail_after_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_rise && !rd_valid_fall) |-> $past(rd_valid_rise && rd_valid_fall));

  // R1: the snapshot happens exactly one edge after an accepted read.
  assert_snap_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_snap);

  // R2: the array commit happens exactly one edge after an accepted write.
  assert_commit_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> wr_commit);

  assert_commit_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(wr_acc));

  // R5: forwarding only when both a read and a write were accepted an edge earlier.
  assert_fwd_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> ($past(rd_acc) && $past(wr_acc)));

  // R6: read spacing and reject flag.
  assert_rd_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> !rd_acc);

  assert_rd_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reject |-> ($past(rd_sel) && !$past(rd_acc)));

  // R7: write spacing and reject flag.
  assert_wr_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !wr_acc);

  assert_wr_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> ($past(wr_sel) && !$past(wr_acc)));
endmodule

bind burst4_ddr_sram burst4_ddr_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
  .rd_acc(rd_acc), .wr_acc(wr_acc), .wr_commit(wr_commit),
  .rd_snap(rd_snap), .fwd_hit(fwd_hit),
  .rd_valid_rise(rd_valid_rise), .rd_valid_fall(rd_valid_fall),
  .rd_reject(rd_reject), .wr_reject(wr_reject)
);

// File: tb/tb_burst4_ddr_sram.sv
`timescale 1ns/1ps
module tb_burst4_ddr_sram;
  localparam int DEPTH   = 256;
  localparam int LINE_AW = 6;
  localparam int W       = 18;
  localparam int NV      = 25;
  localparam int NE      = 40;

  typedef struct packed {
    logic       rd;
    logic [5:0] ra;
    logic       wr;
    logic [5:0] wa;
    logic [1:0] be_r;
    logic [1:0] be_f;
    logic       rrej;  // expected: read request of this slot is ignored
    logic       wrej;  // expected: write request of this slot is ignored
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'd0,  1'b1, 6'd5,  2'd3, 2'd3, 1'b0, 1'b0}, // 0  write line 5
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd3, 2'd3, 1'b0, 1'b0}, // 1
    '{1'b0, 6'd0,  1'b1, 6'd9,  2'd3, 2'd3, 1'b0, 1'b0}, // 2  write line 9
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd3, 2'd3, 1'b0, 1'b0}, // 3
    '{1'b1, 6'd5,  1'b1, 6'd20, 2'd3, 2'd3, 1'b0, 1'b0}, // 4  rd 5 / wr 20
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd3, 2'd3, 1'b0, 1'b0}, // 5
    '{1'b1, 6'd9,  1'b1, 6'd5,  2'd1, 2'd2, 1'b0, 1'b0}, // 6  mixed masks on 5
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd3, 2'd0, 1'b0, 1'b0}, // 7
    '{1'b1, 6'd5,  1'b1, 6'd9,  2'd3, 2'd3, 1'b0, 1'b0}, // 8
    '{1'b1, 6'd20, 1'b1, 6'd5,  2'd2, 2'd1, 1'b1, 1'b1}, // 9  both ignored
    '{1'b1, 6'd9,  1'b1, 6'd9,  2'd2, 2'd1, 1'b0, 1'b0}, // 10 same line, same cycle
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd1, 2'd2, 1'b0, 1'b0}, // 11
    '{1'b1, 6'd5,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 12 read before write
    '{1'b0, 6'd0,  1'b1, 6'd5,  2'd3, 2'd3, 1'b0, 1'b0}, // 13
    '{1'b1, 6'd20, 1'b0, 6'd0,  2'd3, 2'd3, 1'b0, 1'b0}, // 14
    '{1'b0, 6'd0,  1'b1, 6'd20, 2'd0, 2'd0, 1'b0, 1'b0}, // 15 fully masked
    '{1'b1, 6'd9,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 16 back-to-back
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 17
    '{1'b1, 6'd5,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 18
    '{1'b1, 6'd9,  1'b0, 6'd0,  2'd0, 2'd0, 1'b1, 1'b0}, // 19 read ignored
    '{1'b1, 6'd20, 1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 20
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 21
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 22
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}, // 23
    '{1'b0, 6'd0,  1'b0, 6'd0,  2'd0, 2'd0, 1'b0, 1'b0}  // 24
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rd_sel = 1'b0, wr_sel = 1'b0;
  logic [LINE_AW-1:0] addr_rise = '0, addr_fall = '0;
  logic [W-1:0]       wr_data_rise = '0, wr_data_fall = '0;
  logic [1:0]         wr_be_rise = '0, wr_be_fall = '0;
  logic [W-1:0]       rd_data_rise, rd_data_fall;
  logic               rd_valid_rise, rd_valid_fall, rd_reject, wr_reject;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] ref_mem [DEPTH];
  logic         e_vr [NE];
  logic         e_vf [NE];
  logic [W-1:0] e_dr [NE];
  logic [W-1:0] e_df [NE];
  logic         e_rrej [NE];
  logic         e_wrej [NE];
  string        e_tag [NE];

  always #2.5 clk = ~clk;

  burst4_ddr_sram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .addr_rise(addr_rise), .addr_fall(addr_fall),
    .wr_data_rise(wr_data_rise), .wr_data_fall(wr_data_fall),
    .wr_be_rise(wr_be_rise), .wr_be_fall(wr_be_fall),
    .rd_data_rise(rd_data_rise), .rd_data_fall(rd_data_fall),
    .rd_valid_rise(rd_valid_rise), .rd_valid_fall(rd_valid_fall),
    .rd_reject(rd_reject), .wr_reject(wr_reject)
  );

  function automatic logic [W-1:0] pat(int slot, int half);
    return W'((slot * 2 + half) * 4663 + 1234);
  endfunction

  function automatic int widx(logic [5:0] line, int beat);
    return int'(line) * 4 + beat;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Apply a write of the slot-s burst to the reference (beats 2,3 from slot s+1).
  task automatic ref_write(input int s);
    for (int b = 0; b < 4; b++) begin
      int sl;
      int h;
      logic [1:0] m;
      logic [W-1:0] d;
      sl = s + b / 2;
      h  = b % 2;
      m  = h ? VEC[sl].be_f : VEC[sl].be_r;
      d  = pat(sl, h);
      for (int l = 0; l < 2; l++) begin
        if (m[l]) ref_mem[widx(VEC[s].wa, b)][l*9 +: 9] = d[l*9 +: 9];
      end
    end
  endtask

  function automatic string read_tag(int s);
    case (s)
      4:       return "R1 R4";
      6:       return "R3 R4";
      8:       return "R3";
      10:      return "R5";
      12:      return "R7 R10";
      14, 16:  return "R9";
      18:      return "R2";
      20:      return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic ref_read(input int s);
    logic [5:0] ln;
    ln = VEC[s].ra;
    e_vf[s+2] = 1'b1; e_df[s+2] = ref_mem[widx(ln, 0)];
    e_vr[s+3] = 1'b1; e_dr[s+3] = ref_mem[widx(ln, 1)];
    e_vf[s+3] = 1'b1; e_df[s+3] = ref_mem[widx(ln, 2)];
    e_vr[s+4] = 1'b1; e_dr[s+4] = ref_mem[widx(ln, 3)];
    for (int k = 2; k <= 4; k++) e_tag[s+k] = read_tag(s);
  endtask

  task automatic check_slot(input int s);
    chk(rd_valid_rise === e_vr[s], e_tag[s], $sformatf("slot %0d valid_rise", s), 32'(rd_valid_rise), 32'(e_vr[s]));
    chk(rd_valid_fall === e_vf[s], e_tag[s], $sformatf("slot %0d valid_fall", s), 32'(rd_valid_fall), 32'(e_vf[s]));
    chk(rd_data_rise === e_dr[s], e_tag[s], $sformatf("slot %0d data_rise", s), 32'(rd_data_rise), 32'(e_dr[s]));
    chk(rd_data_fall === e_df[s], e_tag[s], $sformatf("slot %0d data_fall", s), 32'(rd_data_fall), 32'(e_df[s]));
    chk(rd_reject === e_rrej[s], "R6", $sformatf("slot %0d rd_reject", s), 32'(rd_reject), 32'(e_rrej[s]));
    chk(wr_reject === e_wrej[s], "R7", $sformatf("slot %0d wr_reject", s), 32'(wr_reject), 32'(e_wrej[s]));
  endtask

  task automatic check_idle(input string what);
    chk(rd_valid_rise === 1'b0 && rd_valid_fall === 1'b0, "R8", {what, " valid"},
        {30'd0, rd_valid_rise, rd_valid_fall}, 32'd0);
    chk(rd_data_rise === '0 && rd_data_fall === '0, "R8", {what, " data"},
        32'(rd_data_rise ^ rd_data_fall), 32'd0);
    chk(rd_reject === 1'b0 && wr_reject === 1'b0, "R8", {what, " rejects"},
        {30'd0, rd_reject, wr_reject}, 32'd0);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    for (int i = 0; i < NE; i++) begin
      e_vr[i] = 1'b0; e_vf[i] = 1'b0; e_dr[i] = '0; e_df[i] = '0;
      e_rrej[i] = 1'b0; e_wrej[i] = 1'b0; e_tag[i] = "R1";
    end

    // Reset state (R8)
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;

    // Vector walk
    for (int s = 0; s < NV; s++) begin
      @(negedge clk);
      check_slot(s);
      e_rrej[s+1] = VEC[s].rd & VEC[s].rrej;
      e_wrej[s+1] = VEC[s].wr & VEC[s].wrej;
      if (VEC[s].wr && !VEC[s].wrej) ref_write(s);
      if (VEC[s].rd && !VEC[s].rrej) ref_read(s);
      rd_sel       = VEC[s].rd;
      addr_rise    = VEC[s].ra;
      wr_sel       = VEC[s].wr;
      addr_fall    = VEC[s].wa;
      wr_data_rise = pat(s, 0);
      wr_data_fall = pat(s, 1);
      wr_be_rise   = VEC[s].be_r;
      wr_be_fall   = VEC[s].be_f;
    end

    // Directed: reset in the middle of a read burst (R8)
    @(negedge clk);
    rd_sel = 1'b1; addr_rise = 6'd5; wr_sel = 1'b0;
    @(negedge clk);
    rd_sel = 1'b0;
    @(negedge clk);
    chk(rd_valid_fall === 1'b1 && rd_data_fall === ref_mem[widx(6'd5, 0)], "R1",
        "directed word 0", 32'(rd_data_fall), 32'(ref_mem[widx(6'd5, 0)]));
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("reset mid-burst");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("after reset, beat 1-2 slot");
    @(negedge clk);
    check_idle("after reset, beat 3 slot");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule